// File: doc/BRIEF.md
# Multichannel Sample-and-Scan Sequencer

This block drives one angle converter that many channels share. Each channel has its own sine/cosine sample-hold pair. When the reference carrier peaks, the block raises one common hold strobe, so that every channel is frozen in the same cycle. It then works through a programmable scan table. For each table entry it selects that entry's channel on the multiplexer address, starts a conversion and waits for the converter to report done. It then emits the converted word, tagged with the channel number and the number of the current pass.

Each channel has a divisor, which sets how often the channel is visited. A channel takes part in a pass only when the pass count is a multiple of its divisor. This lets some channels be read every pass and others only now and then, in any order the table gives. A second mode samples and converts a single table entry per carrier peak and walks the table across successive peaks. A peak that arrives while a scan is still in progress is refused and flagged as an overrun.

Top module: `ssq_top`

## Requirements
- R1: A carrier peak sampled while the block is idle produces exactly one cycle of `hold_strobe` in the next cycle, in both modes. `busy` is high from that cycle until the scan has finished.
- R2: In simultaneous mode (`seq_mode`=0), the scan table entries are visited in index order 0 up to the effective length minus one, and each entry holds a channel number. For each visited channel, `mux_addr` is set to the channel and `conv_start` pulses for one cycle. The block then waits for `conv_done` before it moves on.
- R3: One cycle after `conv_done` is sampled during a wait, `res_valid` pulses for one cycle. In that cycle `res_data` equals the sampled `conv_data`, and `res_ch` equals the channel being converted.
- R4: `mux_addr` stays constant from the `conv_start` pulse until `conv_done` is sampled.
- R5: In simultaneous mode, a channel whose divisor is 0 is never converted. A channel with divisor d > 0 is converted in a pass only when the pass count modulo d is 0. A divisor of 1 therefore means every pass.
- R6: The pass count is 0 after reset. It rises by one, modulo 2^PASS_W, at the end of every simultaneous pass, including a pass with no conversions. `res_pass` carries the count of the pass that produced the result.
- R7: A carrier peak sampled while `busy` is high gives a one-cycle `overrun` pulse in the next cycle. It gives no `hold_strobe`, adds no conversion, and leaves the scan in progress unchanged.
- R8: In sequential mode (`seq_mode`=1), each accepted peak converts exactly one table entry, the one at the current position, whatever its channel's divisor. The position advances by one. After the last entry within the effective length, the position wraps to 0 and the pass count rises by one.
- R9: The effective table length is `tbl_len`, with 0 treated as 1 and any value above DEPTH treated as DEPTH.
- R10: After reset, table entry k holds channel k modulo NCH and every divisor is 1. `hold_strobe`, `conv_start`, `res_valid`, `overrun` and `busy` are all low.
- R11: A write with `tbl_we` stores `tbl_wch` in entry `tbl_waddr`. A write with `div_we` stores `div_wval` as the divisor of channel `div_wch`. Both writes apply to every peak that follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_mode | input | 1 | 0 = simultaneous scan, 1 = one entry per peak |
| carrier_peak | input | 1 | One-cycle carrier-peak event |
| tbl_len | input | LEN_W | Requested scan table length |
| tbl_we | input | 1 | Scan table write enable |
| tbl_waddr | input | IDX_W | Scan table entry to write |
| tbl_wch | input | CH_W | Channel number to store |
| div_we | input | 1 | Divisor write enable |
| div_wch | input | CH_W | Channel whose divisor is written |
| div_wval | input | DIV_W | Divisor value (0 = never in simultaneous mode) |
| conv_done | input | 1 | Converter finished (one-cycle pulse) |
| conv_data | input | DATA_W | Converter result, valid with conv_done |
| hold_strobe | output | 1 | Common hold command to all sample-holds |
| mux_addr | output | CH_W | Channel selected on the multiplexer |
| conv_start | output | 1 | Conversion start pulse |
| res_valid | output | 1 | Result valid pulse |
| res_ch | output | CH_W | Channel of the result |
| res_pass | output | PASS_W | Pass count of the result |
| res_data | output | DATA_W | Converted word |
| overrun | output | 1 | Peak refused because a scan was running |
| busy | output | 1 | A scan or conversion is in progress |

## Verification
The sharpest case is a carrier peak that lands in the same cycle as the `conv_done` of the last entry of a pass. The final result and pass end are then still pending, so the peak has to be refused. The bench's converter model provokes this on purpose: it raises the peak together with the done pulse whenever exactly one expected result of the pass is outstanding. The check then requires an `overrun` pulse with no strobe in the next cycle, the final result with the correct channel and pass, and no extra conversion afterwards. Peaks that arrive earlier, in the middle of a scan, are injected at random and judged in the same way.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PICK = 2'd1,
    ST_WAIT = 2'd2
  } ssq_state_e;

  // channel takes part when its divisor is non-zero and divides the pass count
  function automatic logic pass_hits(input logic [31:0] pass_cnt, input logic [31:0] divisor);
    if (divisor == 32'd0) return 1'b0;
    return (pass_cnt % divisor) == 32'd0;
  endfunction

  // requested table length forced into 1..depth
  function automatic logic [31:0] clamp_len(input logic [31:0] req, input logic [31:0] depth);
    if (req == 32'd0) return 32'd1;
    if (req > depth) return depth;
    return req;
  endfunction

endpackage

// File: rtl/ssq_scan_table.sv
module ssq_scan_table #(
  parameter int NCH   = 8,
  parameter int DEPTH = 8,
  parameter int DIV_W = 4,
  localparam int CH_W  = $clog2(NCH),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_waddr,
  input  logic [CH_W-1:0]  tbl_wch,
  input  logic             div_we,
  input  logic [CH_W-1:0]  div_wch,
  input  logic [DIV_W-1:0] div_wval,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CH_W-1:0]  rd_ch,
  output logic [DIV_W-1:0] rd_div
);

  logic [CH_W-1:0]  order_q [DEPTH];
  logic [DIV_W-1:0] div_q   [NCH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        order_q[g] <= CH_W'(g % NCH);
      else if (tbl_we && (32'(tbl_waddr) == g))
        order_q[g] <= tbl_wch;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_div
    always_ff @(posedge clk) begin
      if (!rst_n)
        div_q[g] <= DIV_W'(1);
      else if (div_we && (32'(div_wch) == g))
        div_q[g] <= div_wval;
    end
  end

  always_comb begin
    rd_ch = '0;
    for (int k = 0; k < DEPTH; k++)
      if (32'(rd_idx) == k) rd_ch = order_q[k];
  end

  always_comb begin
    rd_div = '0;
    for (int k = 0; k < NCH; k++)
      if (32'(rd_ch) == k) rd_div = div_q[k];
  end

endmodule

// File: rtl/ssq_visit_filter.sv
module ssq_visit_filter #(
  parameter int DIV_W  = 4,
  parameter int PASS_W = 6
) (
  input  logic              seq_mode,
  input  logic [PASS_W-1:0] pass_cnt,
  input  logic [DIV_W-1:0]  divisor,
  output logic              visit
);

  logic due;
  assign due   = ssq_pkg::pass_hits(32'(pass_cnt), 32'(divisor));
  // sequential mode converts whatever entry it lands on
  assign visit = seq_mode | due;

endmodule

// File: rtl/ssq_scan_ctrl.sv
module ssq_scan_ctrl #(
  parameter int CH_W   = 3,
  parameter int IDX_W  = 3,
  parameter int LEN_W  = 4,
  parameter int PASS_W = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_mode,
  input  logic              peak,
  input  logic [LEN_W-1:0]  len_eff,
  input  logic [CH_W-1:0]   entry_ch,
  input  logic              visit,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [IDX_W-1:0]  idx,
  output logic [PASS_W-1:0] pass_cnt,
  output logic              hold_strobe,
  output logic [CH_W-1:0]   mux_addr,
  output logic              conv_start,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_ch,
  output logic [PASS_W-1:0] res_pass,
  output logic [DATA_W-1:0] res_data,
  output logic              overrun,
  output logic              busy
);
  import ssq_pkg::*;

  ssq_state_e st_q;

  // named events
  logic peak_take, peak_drop, at_last, waiting, conv_fin, pick_skip;
  assign peak_take = peak && (st_q == ST_IDLE);
  assign peak_drop = peak && (st_q != ST_IDLE);
  assign at_last   = (32'(idx) + 32'd1) >= 32'(len_eff);
  assign waiting   = (st_q == ST_WAIT);
  assign conv_fin  = waiting && conv_done;
  assign pick_skip = (st_q == ST_PICK) && !visit;
  assign busy      = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      idx         <= '0;
      pass_cnt    <= '0;
      hold_strobe <= 1'b0;
      mux_addr    <= '0;
      conv_start  <= 1'b0;
      res_valid   <= 1'b0;
      res_ch      <= '0;
      res_pass    <= '0;
      res_data    <= '0;
      overrun     <= 1'b0;
    end else begin
      hold_strobe <= 1'b0;
      conv_start  <= 1'b0;
      res_valid   <= 1'b0;
      overrun     <= peak_drop;
      case (st_q)
        ST_IDLE: begin
          if (peak_take) begin
            hold_strobe <= 1'b1;
            st_q        <= ST_PICK;
            if (!seq_mode) idx <= '0;
          end
        end
        ST_PICK: begin
          if (visit) begin
            mux_addr   <= entry_ch;
            conv_start <= 1'b1;
            st_q       <= ST_WAIT;
          end else if (at_last) begin
            idx      <= '0;
            pass_cnt <= pass_cnt + 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            res_valid <= 1'b1;
            res_ch    <= mux_addr;
            res_pass  <= pass_cnt;
            res_data  <= conv_data;
            if (at_last) begin
              idx      <= '0;
              pass_cnt <= pass_cnt + 1'b1;
              st_q     <= ST_IDLE;
            end else begin
              idx  <= idx + 1'b1;
              st_q <= seq_mode ? ST_IDLE : ST_PICK;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1: strobe is a single-cycle pulse caused by a peak
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    hold_strobe |=> !hold_strobe);
  a_r1_strobe_from_peak: assert property (@(posedge clk) disable iff (!rst_n)
    hold_strobe |-> $past(peak));
  // R2: conversion start is a single-cycle pulse
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R3: a result only follows a converter done
  a_r3_result_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(conv_done));
  // R4: address frozen while the converter works
  a_r4_mux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !conv_done) |=> $stable(mux_addr));
  // R6: pass count only ever steps by one
  a_r6_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_cnt != $past(pass_cnt)) |-> (pass_cnt == PASS_W'($past(pass_cnt) + 1'b1)));
  // R7: a refused peak never strobes
  a_r7_overrun_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !hold_strobe);
  // R8: one conversion per peak in sequential mode
  a_r8_seq_single: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(seq_mode)) |-> !busy);

endmodule

// File: rtl/ssq_top.sv
module ssq_top #(
  parameter int NCH    = 8,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 4,
  parameter int PASS_W = 6,
  parameter int DATA_W = 12,
  localparam int CH_W  = $clog2(NCH),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_mode,
  input  logic              carrier_peak,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_waddr,
  input  logic [CH_W-1:0]   tbl_wch,
  input  logic              div_we,
  input  logic [CH_W-1:0]   div_wch,
  input  logic [DIV_W-1:0]  div_wval,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              hold_strobe,
  output logic [CH_W-1:0]   mux_addr,
  output logic              conv_start,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_ch,
  output logic [PASS_W-1:0] res_pass,
  output logic [DATA_W-1:0] res_data,
  output logic              overrun,
  output logic              busy
);

  logic [LEN_W-1:0]  len_eff;
  logic [IDX_W-1:0]  cur_idx;
  logic [CH_W-1:0]   cur_ch;
  logic [DIV_W-1:0]  cur_div;
  logic [PASS_W-1:0] pass_cnt;
  logic              visit;

  assign len_eff = LEN_W'(ssq_pkg::clamp_len(32'(tbl_len), 32'(DEPTH)));

  ssq_scan_table #(.NCH(NCH), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wch(tbl_wch),
    .div_we(div_we), .div_wch(div_wch), .div_wval(div_wval),
    .rd_idx(cur_idx), .rd_ch(cur_ch), .rd_div(cur_div)
  );

  ssq_visit_filter #(.DIV_W(DIV_W), .PASS_W(PASS_W)) u_filter (
    .seq_mode(seq_mode), .pass_cnt(pass_cnt), .divisor(cur_div), .visit(visit)
  );

  ssq_scan_ctrl #(.CH_W(CH_W), .IDX_W(IDX_W), .LEN_W(LEN_W),
                  .PASS_W(PASS_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .peak(carrier_peak),
    .len_eff(len_eff), .entry_ch(cur_ch), .visit(visit),
    .conv_done(conv_done), .conv_data(conv_data),
    .idx(cur_idx), .pass_cnt(pass_cnt), .hold_strobe(hold_strobe),
    .mux_addr(mux_addr), .conv_start(conv_start), .res_valid(res_valid),
    .res_ch(res_ch), .res_pass(res_pass), .res_data(res_data),
    .overrun(overrun), .busy(busy)
  );

endmodule

// File: tb/ssq_top_tb.sv
module ssq_top_tb;
  localparam int NCH = 8, DEPTH = 8, DIV_W = 4, PASS_W = 6, DATA_W = 12;
  localparam int PMOD = 1 << PASS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_mode = 1'b0;
  logic peak_main = 1'b0, peak_conv = 1'b0;
  logic [3:0] tbl_len = 4'd8;
  logic tbl_we = 1'b0, div_we = 1'b0;
  logic [2:0] tbl_waddr = '0, tbl_wch = '0, div_wch = '0;
  logic [3:0] div_wval = '0;
  logic conv_done = 1'b0;
  logic [DATA_W-1:0] conv_data = '0;
  logic hold_strobe, conv_start, res_valid, overrun, busy;
  logic [2:0] mux_addr, res_ch;
  logic [PASS_W-1:0] res_pass;
  logic [DATA_W-1:0] res_data;
  logic carrier_peak;
  assign carrier_peak = peak_main | peak_conv;

  always #5 clk = ~clk;

  ssq_top u_dut (
    .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .carrier_peak(carrier_peak),
    .tbl_len(tbl_len), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wch(tbl_wch),
    .div_we(div_we), .div_wch(div_wch), .div_wval(div_wval),
    .conv_done(conv_done), .conv_data(conv_data), .hold_strobe(hold_strobe),
    .mux_addr(mux_addr), .conv_start(conv_start), .res_valid(res_valid),
    .res_ch(res_ch), .res_pass(res_pass), .res_data(res_data),
    .overrun(overrun), .busy(busy)
  );

  int checks = 0, errors = 0;
  int m_tbl [DEPTH];
  int m_div [NCH];
  int exp_ch [0:4095];
  int exp_pass [0:4095];
  int dq [0:4095];
  int ewp = 0, erp = 0, dwp = 0;
  int m_pass = 0, m_pos = 0;
  int cnt = 0;
  bit coin_req = 0, coin_hit = 0, coin_seen = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input int req);
    int r;
    r = req;
    if (r > DEPTH) r = DEPTH;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic bit due(input int p, input int d);
    int q;
    if (d == 0) return 0;
    q = p / d;
    return (q * d) == p;
  endfunction

  task automatic push(input int ch, input int p);
    exp_ch[ewp] = ch;
    exp_pass[ewp] = p;
    ewp++;
  endtask

  task automatic wr_tbl(input int i, input int ch);
    @(negedge clk);
    tbl_we = 1; tbl_waddr = 3'(i); tbl_wch = 3'(ch);
    @(negedge clk);
    tbl_we = 0;
    m_tbl[i] = ch;
  endtask

  task automatic wr_div(input int ch, input int d);
    @(negedge clk);
    div_we = 1; div_wch = 3'(ch); div_wval = 4'(d);
    @(negedge clk);
    div_we = 0;
    m_div[ch] = d;
  endtask

  // one carrier peak with its expected outcome
  task automatic run_peak(input bit sq, input int len_req, input bit inject);
    int le, n;
    n = 0;
    le = len_of(len_req);
    @(negedge clk);
    seq_mode = sq; tbl_len = 4'(len_req);
    if (!sq) begin
      for (int k = 0; k < le; k++)
        if (due(m_pass, m_div[m_tbl[k]])) begin push(m_tbl[k], m_pass); n++; end
      m_pass = (m_pass + 1) % PMOD;
      m_pos = 0;
    end else begin
      push(m_tbl[m_pos], m_pass); n++;
      if (m_pos >= le - 1) begin m_pos = 0; m_pass = (m_pass + 1) % PMOD; end
      else m_pos++;
    end
    peak_main = 1;
    @(negedge clk);
    peak_main = 0;
    chk(hold_strobe == 1'b1, "R1 strobe after peak", int'(hold_strobe), 1);
    chk(busy == 1'b1, "R1 busy after peak", int'(busy), 1);
    @(negedge clk);
    chk(hold_strobe == 1'b0, "R1 strobe one cycle", int'(hold_strobe), 0);
    if (inject && n > 0) begin
      peak_main = 1;
      @(negedge clk);
      peak_main = 0;
      chk(overrun == 1'b1, "R7 overrun pulse", int'(overrun), 1);
      chk(hold_strobe == 1'b0, "R7 no strobe on refused peak", int'(hold_strobe), 0);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(erp == ewp, "R2 all results of peak delivered", erp, ewp);
  endtask

  // converter model, also raises a peak together with a final done on request
  initial begin
    forever begin
      @(negedge clk);
      if (coin_hit) begin
        peak_conv = 0; coin_hit = 0; coin_seen = 1;
        chk(overrun == 1'b1, "R7 peak with last done refused", int'(overrun), 1);
        chk(hold_strobe == 1'b0, "R7 no strobe with last done", int'(hold_strobe), 0);
      end
      conv_done = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          conv_done = 1;
          conv_data = DATA_W'($urandom);
          dq[dwp] = int'(conv_data); dwp++;
          if (coin_req && (ewp - erp == 1)) begin
            peak_conv = 1; coin_hit = 1; coin_req = 0;
          end
        end
      end
      if (conv_start) begin
        chk(int'(mux_addr) == exp_ch[erp], "R2 channel order on mux", int'(mux_addr), exp_ch[erp]);
        cnt = 1 + int'($urandom % 5);
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (erp >= ewp) chk(0, "R2 unexpected result", int'(res_ch), -1);
        else begin
          chk(int'(res_ch) == exp_ch[erp], "R3 result channel", int'(res_ch), exp_ch[erp]);
          chk(int'(res_pass) == exp_pass[erp], "R6 result pass", int'(res_pass), exp_pass[erp]);
          chk(int'(res_data) == dq[erp], "R3 result data", int'(res_data), dq[erp]);
          erp++;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd911));
    for (int k = 0; k < DEPTH; k++) m_tbl[k] = k % NCH;
    for (int k = 0; k < NCH; k++) m_div[k] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(hold_strobe == 0 && conv_start == 0, "R10 strobe/start low", int'(hold_strobe), 0);
    chk(res_valid == 0 && overrun == 0, "R10 valid/overrun low", int'(res_valid), 0);
    chk(busy == 0, "R10 idle", int'(busy), 0);
    // R10 default table, R2 order
    run_peak(0, 8, 0);
    // R11 reversed table, R7 injected mid-scan
    for (int k = 0; k < DEPTH; k++) wr_tbl(k, 7 - k);
    run_peak(0, 8, 1);
    // R5 all divisors zero: nothing converted, pass still advances (R6)
    for (int k = 0; k < NCH; k++) wr_div(k, 0);
    run_peak(0, 8, 0);
    // R5 mixed divisors over several passes, skips and repeats in table
    wr_div(0, 1); wr_div(3, 2); wr_div(5, 3); wr_div(6, 10);
    wr_tbl(1, 3); wr_tbl(4, 3);
    for (int p = 0; p < 6; p++) run_peak(0, 8, p[0]);
    // R9 length clamping
    run_peak(0, 0, 0);
    run_peak(0, 15, 0);
    // R8 sequential mode walks the table, ignoring divisors
    for (int p = 0; p < 10; p++) run_peak(1, 3, 0);
    // peak coinciding with final conversion done
    coin_req = 1;
    run_peak(0, 8, 0);
    repeat (3) @(negedge clk);
    chk(coin_seen == 1, "R7 coincident peak provoked", int'(coin_seen), 1);
    chk(ewp == erp, "R7 no extra conversion after refused peak", erp, ewp);
    // random passes
    for (int p = 0; p < 70; p++) begin
      if ($urandom % 3 == 0) wr_tbl(int'($urandom % DEPTH), int'($urandom % NCH));
      if ($urandom % 3 == 0) wr_div(int'($urandom % NCH), int'($urandom % 5));
      run_peak(($urandom % 5) == 0, int'($urandom % 13), ($urandom % 3) == 0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule